// File: doc/BRIEF.md
# Serial Peripheral Host-Command Buffer

This block is the target (peripheral) end of an SPI link used for host command traffic. The host drives chip select, the serial clock and the data line in SPI mode 0. Every complete byte that arrives is stored in a 128-entry receive store. At the same time, bytes from a separate 128-entry transmit store are shifted back to the host. The serial pins are brought into the core clock through two-flop synchronizers. All sequencing runs on the core clock.

The core reaches the block through a flat byte-wide register window. The window holds three threshold settings, two groups of sticky event flags with matching enable masks, and both stores. One interrupt line is raised when any enabled flag is set. Two receive thresholds compare independently against the receive count. A third threshold watches the transmit read index. Chip-select falling and rising edges are each flagged directly from the synchronized select line, so a select pulse with no clock activity still produces both flags.

Top module: `spi_hostbuf`

## Requirements
- R1: After reset, register 0x01 reads 0x40, 0x02 reads 0x08 and 0x03 reads 0x40. Registers 0x04 to 0x07 read 0x00 and `irq` is low.
- R2: While select is low, the host's bits are sampled on rising SCK, MSB first. The k-th complete byte after a select fall is stored at receive index k, which the core reads at address 0xA0+k.
- R3: The transmit store is written and read by the core at 0x20+k. After a select fall, byte 0 is driven MSB first, and MISO changes after falling SCK edges. Byte k is sent as the k-th byte of the transfer, and 0xFF is sent once k exceeds 127.
- R4: Register 0x01 holds a 7-bit level in bits 6:0 and a disable in bit 7. When the receive count steps to that level, flag 0x04 bit 0 is set, unless it is disabled.
- R5: Register 0x02 holds a 6-bit level in bits 5:0 and a disable in bit 7. When the receive count steps to that level, flag 0x05 bit 0 is set, unless it is disabled. This works independently of R4, and both may hit on the same byte.
- R6: Register 0x03 holds a 7-bit level in bits 6:0 and a disable in bit 7. When the count of completed transmit bytes steps to that level, flag 0x04 bit 1 is set, unless it is disabled.
- R7: A select fall sets 0x05 bit 2 and a select rise sets 0x05 bit 1. This happens even when no SCK edge occurs. A low pulse of three core cycles is enough.
- R8: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. When an event and a clear hit the same cycle, the flag stays set.
- R9: `irq` is the OR of (0x04 AND 0x06) and (0x05 AND 0x07). The enable bits sit at the same bit positions as their flags.
- R10: Bytes received after the 128th in one transfer are dropped. Receive index 0 keeps the first byte.
- R11: Core writes to the receive store window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_csn | input | 1 | Active-low select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high while deselected |
| reg_addr | input | 9 | Register window byte address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act in the same core cycle. The first pair is a flag being set and a core clear of that flag. The bench lowers select and times a write-one-clear of the select-fall flag so that it lands on the exact edge where the synchronized fall is registered. The flag must read back as still set. The second pair is the two receive thresholds: both are programmed to the same level, and after one short transfer both flag groups are expected to show their hits together.

// File: rtl/spi_hostbuf_pkg.sv
package spi_hostbuf_pkg;

    localparam int ADDR_W = 9;

    localparam logic [ADDR_W-1:0] A_ILVL    = 9'h001;
    localparam logic [ADDR_W-1:0] A_ILVL2   = 9'h002;
    localparam logic [ADDR_W-1:0] A_OLVL    = 9'h003;
    localparam logic [ADDR_W-1:0] A_STAT1   = 9'h004;
    localparam logic [ADDR_W-1:0] A_STAT2   = 9'h005;
    localparam logic [ADDR_W-1:0] A_EN1     = 9'h006;
    localparam logic [ADDR_W-1:0] A_EN2     = 9'h007;
    localparam logic [ADDR_W-1:0] OBUF_BASE = 9'h020;
    localparam logic [ADDR_W-1:0] IBUF_BASE = 9'h0A0;

    localparam logic [7:0] ILVL_RST  = 8'h40;
    localparam logic [7:0] ILVL2_RST = 8'h08;
    localparam logic [7:0] OLVL_RST  = 8'h40;

    // primary flags: bit1 transmit level, bit0 receive level
    typedef struct packed {
        logic out_lvl;
        logic in_lvl;
    } ev1_t;

    // secondary flags: bit2 select fall, bit1 select rise, bit0 second receive level
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic in_lvl2;
    } ev2_t;

    typedef struct packed {
        logic       dis;
        logic [6:0] lvl;
    } lvl_cfg_t;

    function automatic logic in_window(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base,
                                       int unsigned depth);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + int'(depth));
    endfunction

endpackage

// File: rtl/spi_hb_sync.sv
module spi_hb_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                s1   <= d[i];
                q[i] <= s1;
            end
        end
    end
endmodule

// File: rtl/spi_hb_engine.sv
module spi_hb_engine #(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csn_s,
    input  logic             sck_s,
    input  logic             mosi_s,
    input  logic [7:0]       ob_rdata,
    output logic [PTR_W-1:0] ob_raddr,
    output logic             ib_we,
    output logic [IDX_W-1:0] ib_waddr,
    output logic [7:0]       ib_wdata,
    output logic             wr_evt,
    output logic [PTR_W-1:0] wr_cnt,
    output logic             rd_evt,
    output logic [PTR_W-1:0] rd_cnt,
    output logic             cs_fall,
    output logic             cs_rise,
    output logic [PTR_W-1:0] wptr,
    output logic             miso
);
    logic             csn_q, sck_q;
    logic [2:0]       bitcnt;
    logic [6:0]       rx;
    logic [7:0]       tx;
    logic [PTR_W-1:0] rd_idx, rd_nxt;
    logic             sck_rise, sck_fall, byte_done;

    assign cs_fall  = csn_q & ~csn_s;
    assign cs_rise  = ~csn_q & csn_s;
    assign sck_rise = ~csn_s & ~sck_q & sck_s;
    assign sck_fall = ~csn_s & sck_q & ~sck_s;

    assign byte_done = sck_rise & (bitcnt == 3'd7) & ~cs_fall;
    assign ib_we     = byte_done & ~wptr[IDX_W];
    assign ib_waddr  = wptr[IDX_W-1:0];
    assign ib_wdata  = {rx, mosi_s};
    assign wr_evt    = ib_we;
    assign wr_cnt    = wptr + 1'b1;

    assign rd_nxt    = rd_idx[IDX_W] ? rd_idx : rd_idx + 1'b1;
    assign rd_evt    = sck_fall & (bitcnt == 3'd0) & ~cs_fall;
    assign rd_cnt    = rd_nxt;
    assign ob_raddr  = cs_fall ? '0 : rd_nxt;

    assign miso      = csn_s ? 1'b1 : tx[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q  <= 1'b1;
            sck_q  <= 1'b0;
            bitcnt <= '0;
            rx     <= '0;
            tx     <= 8'hFF;
            wptr   <= '0;
            rd_idx <= '0;
        end else begin
            csn_q <= csn_s;
            sck_q <= sck_s;
            if (cs_fall) begin
                bitcnt <= '0;
                rx     <= '0;
                wptr   <= '0;
                rd_idx <= '0;
                tx     <= ob_rdata;
            end else begin
                if (sck_rise) begin
                    rx     <= {rx[5:0], mosi_s};
                    bitcnt <= bitcnt + 3'd1;
                    if (ib_we)
                        wptr <= wptr + 1'b1;
                end
                if (sck_fall) begin
                    if (bitcnt == 3'd0) begin
                        rd_idx <= rd_nxt;
                        tx     <= ob_rdata;
                    end else begin
                        tx     <= {tx[6:0], 1'b1};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_hb_events.sv
module spi_hb_events
    import spi_hostbuf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  lvl_cfg_t         ilvl,
    input  logic             ilvl2_dis,
    input  logic [5:0]       ilvl2_lvl,
    input  lvl_cfg_t         olvl,
    input  logic             wr_evt,
    input  logic [PTR_W-1:0] wr_cnt,
    input  logic             rd_evt,
    input  logic [PTR_W-1:0] rd_cnt,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  ev1_t             w1c1,
    input  ev2_t             w1c2,
    input  logic             en1_we,
    input  ev1_t             en1_d,
    input  logic             en2_we,
    input  ev2_t             en2_d,
    output ev1_t             stat1,
    output ev2_t             stat2,
    output ev1_t             en1,
    output ev2_t             en2,
    output logic             irq
);
    ev1_t set1;
    ev2_t set2;

    always_comb begin
        set1.in_lvl   = wr_evt & ~ilvl.dis & (wr_cnt == PTR_W'(ilvl.lvl));
        set1.out_lvl  = rd_evt & ~olvl.dis & (rd_cnt == PTR_W'(olvl.lvl));
        set2.in_lvl2  = wr_evt & ~ilvl2_dis & (wr_cnt == PTR_W'(ilvl2_lvl));
        set2.cs_rise  = cs_rise;
        set2.cs_fall  = cs_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat1 <= '0;
            stat2 <= '0;
            en1   <= '0;
            en2   <= '0;
        end else begin
            stat1 <= (stat1 & ~w1c1) | set1;
            stat2 <= (stat2 & ~w1c2) | set2;
            if (en1_we) en1 <= en1_d;
            if (en2_we) en2 <= en2_d;
        end
    end

    assign irq = (|(stat1 & en1)) | (|(stat2 & en2));
endmodule

// File: rtl/spi_hb_regs.sv
module spi_hb_regs
    import spi_hostbuf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [PTR_W-1:0]  ob_raddr,
    output logic [7:0]        ob_rdata,
    input  logic              ib_we,
    input  logic [IDX_W-1:0]  ib_waddr,
    input  logic [7:0]        ib_wdata,
    input  ev1_t              stat1,
    input  ev2_t              stat2,
    input  ev1_t              en1,
    input  ev2_t              en2,
    output lvl_cfg_t          ilvl,
    output logic              ilvl2_dis,
    output logic [5:0]        ilvl2_lvl,
    output lvl_cfg_t          olvl,
    output ev1_t              w1c1,
    output ev2_t              w1c2,
    output logic              en1_we,
    output ev1_t              en1_d,
    output logic              en2_we,
    output ev2_t              en2_d
);
    logic [7:0] obuf [DEPTH];
    logic [7:0] ibuf [DEPTH];

    logic             ob_hit, ib_hit;
    logic [IDX_W-1:0] ob_off, ib_off;

    assign ob_hit = in_window(reg_addr, OBUF_BASE, DEPTH);
    assign ib_hit = in_window(reg_addr, IBUF_BASE, DEPTH);
    assign ob_off = IDX_W'(reg_addr - OBUF_BASE);
    assign ib_off = IDX_W'(reg_addr - IBUF_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ilvl      <= lvl_cfg_t'(ILVL_RST);
            ilvl2_dis <= ILVL2_RST[7];
            ilvl2_lvl <= ILVL2_RST[5:0];
            olvl      <= lvl_cfg_t'(OLVL_RST);
        end else if (reg_wr) begin
            if (reg_addr == A_ILVL) ilvl <= lvl_cfg_t'(reg_wdata);
            if (reg_addr == A_ILVL2) begin
                ilvl2_dis <= reg_wdata[7];
                ilvl2_lvl <= reg_wdata[5:0];
            end
            if (reg_addr == A_OLVL) olvl <= lvl_cfg_t'(reg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (reg_wr && ob_hit)
            obuf[ob_off] <= reg_wdata;
        if (ib_we)
            ibuf[ib_waddr] <= ib_wdata;
    end

    assign ob_rdata = ob_raddr[IDX_W] ? 8'hFF : obuf[ob_raddr[IDX_W-1:0]];

    always_comb begin
        w1c1   = '0;
        w1c2   = '0;
        en1_we = 1'b0;
        en2_we = 1'b0;
        en1_d  = ev1_t'(reg_wdata[1:0]);
        en2_d  = ev2_t'(reg_wdata[2:0]);
        if (reg_wr) begin
            if (reg_addr == A_STAT1) w1c1 = ev1_t'(reg_wdata[1:0]);
            if (reg_addr == A_STAT2) w1c2 = ev2_t'(reg_wdata[2:0]);
            en1_we = (reg_addr == A_EN1);
            en2_we = (reg_addr == A_EN2);
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (ob_hit)
            reg_rdata = obuf[ob_off];
        else if (ib_hit)
            reg_rdata = ibuf[ib_off];
        else begin
            case (reg_addr)
                A_ILVL:  reg_rdata = ilvl;
                A_ILVL2: reg_rdata = {ilvl2_dis, 1'b0, ilvl2_lvl};
                A_OLVL:  reg_rdata = olvl;
                A_STAT1: reg_rdata = {6'd0, stat1};
                A_STAT2: reg_rdata = {5'd0, stat2};
                A_EN1:   reg_rdata = {6'd0, en1};
                A_EN2:   reg_rdata = {5'd0, en2};
                default: reg_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/spi_hostbuf.sv
module spi_hostbuf
    import spi_hostbuf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic             csn_s, sck_s, mosi_s;
    logic [PTR_W-1:0] ob_raddr, wr_cnt, rd_cnt, wptr;
    logic [7:0]       ob_rdata, ib_wdata;
    logic [IDX_W-1:0] ib_waddr;
    logic             ib_we, wr_evt, rd_evt, cs_fall, cs_rise;
    lvl_cfg_t         ilvl, olvl;
    logic             ilvl2_dis;
    logic [5:0]       ilvl2_lvl;
    ev1_t             stat1, en1, w1c1, en1_d;
    ev2_t             stat2, en2, w1c2, en2_d;
    logic             en1_we, en2_we;

    spi_hb_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_csn, spi_sck, spi_mosi}),
        .q   ({csn_s, sck_s, mosi_s})
    );

    spi_hb_engine #(.DEPTH(DEPTH)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .csn_s    (csn_s),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .ob_rdata (ob_rdata),
        .ob_raddr (ob_raddr),
        .ib_we    (ib_we),
        .ib_waddr (ib_waddr),
        .ib_wdata (ib_wdata),
        .wr_evt   (wr_evt),
        .wr_cnt   (wr_cnt),
        .rd_evt   (rd_evt),
        .rd_cnt   (rd_cnt),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .wptr     (wptr),
        .miso     (spi_miso)
    );

    spi_hb_regs #(.DEPTH(DEPTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ob_raddr  (ob_raddr),
        .ob_rdata  (ob_rdata),
        .ib_we     (ib_we),
        .ib_waddr  (ib_waddr),
        .ib_wdata  (ib_wdata),
        .stat1     (stat1),
        .stat2     (stat2),
        .en1       (en1),
        .en2       (en2),
        .ilvl      (ilvl),
        .ilvl2_dis (ilvl2_dis),
        .ilvl2_lvl (ilvl2_lvl),
        .olvl      (olvl),
        .w1c1      (w1c1),
        .w1c2      (w1c2),
        .en1_we    (en1_we),
        .en1_d     (en1_d),
        .en2_we    (en2_we),
        .en2_d     (en2_d)
    );

    spi_hb_events #(.DEPTH(DEPTH)) u_events (
        .clk       (clk),
        .rst       (rst),
        .ilvl      (ilvl),
        .ilvl2_dis (ilvl2_dis),
        .ilvl2_lvl (ilvl2_lvl),
        .olvl      (olvl),
        .wr_evt    (wr_evt),
        .wr_cnt    (wr_cnt),
        .rd_evt    (rd_evt),
        .rd_cnt    (rd_cnt),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .w1c1      (w1c1),
        .w1c2      (w1c2),
        .en1_we    (en1_we),
        .en1_d     (en1_d),
        .en2_we    (en2_we),
        .en2_d     (en2_d),
        .stat1     (stat1),
        .stat2     (stat2),
        .en1       (en1),
        .en2       (en2),
        .irq       (irq)
    );
endmodule

// File: rtl/spi_hostbuf_chk.sv
module spi_hostbuf_chk
    import spi_hostbuf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             csn_s,
    input logic             cs_fall,
    input logic             cs_rise,
    input logic             ib_we,
    input logic [PTR_W-1:0] wptr,
    input ev1_t             stat1,
    input ev2_t             stat2,
    input logic             irq
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat1 == '0 && stat2 == '0 && !irq));

    // R2
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        csn_s |-> !ib_we);

    // R7
    cs_fall_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> stat2.cs_fall);

    // R7
    cs_rise_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> stat2.cs_rise);

    // R8
    clear_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat2.cs_rise) |-> $past(reg_wr));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(wptr) <= DEPTH);
endmodule

bind spi_hostbuf spi_hostbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_wr  (reg_wr),
    .csn_s   (csn_s),
    .cs_fall (cs_fall),
    .cs_rise (cs_rise),
    .ib_we   (ib_we),
    .wptr    (wptr),
    .stat1   (stat1),
    .stat2   (stat2),
    .irq     (irq)
);

// File: tb/spi_hostbuf_test.sv
module spi_hostbuf_test;
    import spi_hostbuf_pkg::*;

    localparam int HALF = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic             spi_miso;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];

    always #2 clk = ~clk;

    spi_hostbuf uut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] obuf_pat(int k);
        return 8'((k * 7) + 3);
    endfunction

    function automatic logic [7:0] mosi_pat(int k, int seed);
        return 8'((k * 13) + seed);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(string req, logic [ADDR_W-1:0] a, logic [7:0] e);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, e);
    endtask

    task automatic clear_flags();
        reg_write(A_STAT1, 8'hFF);
        reg_write(A_STAT2, 8'hFF);
    endtask

    task automatic spi_byte(logic [7:0] t);
        logic [7:0] r;
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = t[i];
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            r[i] = spi_miso;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        got_q.push_back(r);
    endtask

    // driver: expected MISO bytes go to the scoreboard before each byte is shifted
    task automatic xfer(int n, int seed);
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(k < 128 ? obuf_pat(k) : 8'hFF);
            spi_byte(mosi_pat(k, seed));
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    // monitor: R3 stream comparison
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g, e;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                check("R3 miso byte", g, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg("R1 ilvl", A_ILVL, 8'h40);
        expect_reg("R1 ilvl2", A_ILVL2, 8'h08);
        expect_reg("R1 olvl", A_OLVL, 8'h40);
        expect_reg("R1 stat1", A_STAT1, 8'h00);
        expect_reg("R1 stat2", A_STAT2, 8'h00);
        expect_reg("R1 en1", A_EN1, 8'h00);
        expect_reg("R1 en2", A_EN2, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        for (int k = 0; k < 128; k++) reg_write(OBUF_BASE + 9'(k), obuf_pat(k));
        expect_reg("R3 obuf readback", OBUF_BASE + 9'd5, obuf_pat(5));
        expect_reg("R3 obuf readback", OBUF_BASE + 9'd127, obuf_pat(127));

        // R2 short transfer
        xfer(4, 8'h11);
        for (int k = 0; k < 4; k++)
            expect_reg("R2 ibuf", IBUF_BASE + 9'(k), mosi_pat(k, 8'h11));
        expect_reg("R7 stat2 edges", A_STAT2, 8'h06);
        expect_reg("R4 no level at 4", A_STAT1, 8'h00);
        clear_flags();
        expect_reg("R8 cleared", A_STAT2, 8'h00);

        // R5 default second level of 8, R9 irq
        xfer(10, 8'h22);
        expect_reg("R5 level2 hit", A_STAT2, 8'h07);
        check("R9 irq masked", {7'd0, irq}, 8'h00);
        reg_write(A_EN2, 8'h01);
        #1 check("R9 irq on", {7'd0, irq}, 8'h01);
        reg_write(A_STAT2, 8'h01);
        expect_reg("R8 only bit0 cleared", A_STAT2, 8'h06);
        check("R9 irq off", {7'd0, irq}, 8'h00);
        reg_write(A_EN2, 8'h00);
        clear_flags();

        // R4 R5 R6 same-level hits
        reg_write(A_ILVL, 8'h03);
        reg_write(A_ILVL2, 8'h03);
        reg_write(A_OLVL, 8'h02);
        xfer(5, 8'h33);
        expect_reg("R4 R6 stat1", A_STAT1, 8'h03);
        expect_reg("R5 stat2", A_STAT2, 8'h07);
        reg_write(A_EN1, 8'h02);
        #1 check("R9 irq primary", {7'd0, irq}, 8'h01);
        reg_write(A_EN1, 8'h00);
        clear_flags();

        // disables
        reg_write(A_ILVL, 8'h83);
        reg_write(A_ILVL2, 8'h83);
        reg_write(A_OLVL, 8'h82);
        xfer(5, 8'h44);
        expect_reg("R4 R6 disabled", A_STAT1, 8'h00);
        expect_reg("R5 disabled", A_STAT2, 8'h06);
        clear_flags();

        // R7 glitch without SCK
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (3) @(negedge clk);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);
        expect_reg("R7 glitch edges", A_STAT2, 8'h06);
        clear_flags();

        // R8 set wins over a same-cycle clear
        @(negedge clk);
        spi_csn = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = A_STAT2; reg_wdata = 8'h04; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        expect_reg("R8 set wins", A_STAT2, 8'h04);
        repeat (4) @(negedge clk);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);
        clear_flags();
        expect_reg("R8 clear", A_STAT2, 8'h00);

        // R3 R10 long transfer with defaults restored
        reg_write(A_ILVL, 8'h40);
        reg_write(A_ILVL2, 8'h08);
        reg_write(A_OLVL, 8'h40);
        xfer(130, 8'h5A);
        expect_reg("R10 ibuf0 kept", IBUF_BASE, mosi_pat(0, 8'h5A));
        expect_reg("R10 ibuf127", IBUF_BASE + 9'd127, mosi_pat(127, 8'h5A));
        expect_reg("R4 R6 default levels", A_STAT1, 8'h03);
        expect_reg("R5 R7 stat2", A_STAT2, 8'h07);

        // R11 receive store is read-only to the core
        reg_write(IBUF_BASE, 8'h00);
        expect_reg("R11 ibuf write ignored", IBUF_BASE, mosi_pat(0, 8'h5A));

        repeat (20) @(negedge clk);
        check("R3 scoreboard drained", 8'(exp_q.size() + got_q.size()), 8'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule